// File: doc/BRIEF.md
# Snapshot Error-Event Counter Bank

This block keeps a bank of saturating counters for error events seen by a framed line receiver. Typical events are framing-bit errors, parity errors and far-end block errors. Each event type has its own one-cycle count-enable input and its own live counter. There is no qualifier input: counting goes on whether or not the receiver is in frame. The counters are 16 bits wide by default. A one-second poll of a 44.736 Mb/s line at a 1e-3 error rate produces about 44.7 thousand events, so the counters do not saturate in that interval.

Software polls the bank about once a second. A pulse on the write strobe moves every live count into that counter's holding register and clears every live counter on the same clock edge. An event that arrives in the strobe cycle is added to the value being held, so no event is lost and none is counted twice. Software then reads the holding registers one address at a time through a registered read port.

Top module: `pec_bank`

## Requirements
- R1: Counter k (k = 0..NUM_CTR-1) is driven by `evt_i[k]` alone and is read back at address k. An event on one input never changes another counter.
- R2: A live counter gains exactly one for every clock cycle its enable is high, including back-to-back cycles. No receiver status gates the count.
- R3: A live counter that reaches 2^CTR_W-1 (65535 by default) holds that value, without wrapping, until the next transfer.
- R4: In a cycle with `wr_i` high, every holding register loads its live count plus that cycle's event (saturating at 2^CTR_W-1), and every live counter becomes 0. The strobe-cycle event is not carried into the new live count.
- R5: A holding register changes only on a transfer. Events without a strobe leave the values read back unchanged.
- R6: `rdata_o` shows the holding register selected by `addr_i` one clock after the address is presented. An address of NUM_CTR or above reads as 0.
- R7: While `rst` is high at a clock edge, all live counters, holding registers and `rdata_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_CTR | One count-enable per error-event type, bit k feeds counter k |
| wr_i | input | 1 | Host write strobe: transfer live counts to holding registers and clear the live counts |
| addr_i | input | ADDR_W | Read address, holding register k at address k |
| rdata_o | output | CTR_W | Registered read data |

## Verification
The hardest state to reach from the ports is a saturated counter, because it takes more than 65 thousand events. The stimulus holds two enables high for 66,000 consecutive cycles and then strobes. It expects 65535 in both holding registers and 0 in the idle one. A second hard case puts an event in the strobe cycle itself. The bench then strobes again at once and expects 0, which shows that the event went to the held value and not to the new live count. A table of event bursts and strobe-cycle events, each followed by a read of every address, covers the ordinary counting.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int unsigned PEC_NUM_CTR = 3;
    localparam int unsigned PEC_CTR_W   = 16;
    localparam int unsigned PEC_ADDR_W  = 4;

    // Per-cycle control seen by one counter cell
    typedef struct packed {
        logic snap;   // transfer strobe
        logic evt;    // count enable
    } pec_ctl_t;

    // What the live counter does this cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_SNAP = 2'd2
    } pec_step_e;

    function automatic pec_step_e pec_pick_step(input pec_ctl_t c);
        if (c.snap)     return STEP_SNAP;
        else if (c.evt) return STEP_INC;
        else            return STEP_HOLD;
    endfunction
endpackage

// File: rtl/pec_cell.sv
module pec_cell
    import pec_pkg::*;
#(
    parameter int unsigned CTR_W = PEC_CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  pec_ctl_t         ctl_i,
    output logic [CTR_W-1:0] live_o,
    output logic [CTR_W-1:0] hold_o
);
    localparam logic [CTR_W-1:0] TOP_VAL = {CTR_W{1'b1}};

    logic [CTR_W-1:0] live_q, hold_q;
    logic [CTR_W-1:0] bumped, live_d, hold_d;
    pec_step_e        step;

    always_comb begin
        step   = pec_pick_step(ctl_i);
        bumped = (live_q == TOP_VAL) ? live_q : live_q + CTR_W'(1);
        live_d = live_q;
        hold_d = hold_q;
        unique case (step)
            STEP_INC:  live_d = bumped;
            STEP_SNAP: begin
                live_d = '0;
                hold_d = ctl_i.evt ? bumped : live_q;
            end
            default:   live_d = live_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            hold_q <= '0;
        end else begin
            live_q <= live_d;
            hold_q <= hold_d;
        end
    end

    assign live_o = live_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/pec_rd_port.sv
module pec_rd_port #(
    parameter int unsigned NUM_CTR = 3,
    parameter int unsigned CTR_W   = 16,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]  hold_i,
    output logic [CTR_W-1:0]               rdata_o
);
    logic [CTR_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (addr_i == ADDR_W'(k)) rdata_d = hold_i[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_o <= '0;
        else     rdata_o <= rdata_d;
    end
endmodule

// File: rtl/pec_bank.sv
module pec_bank
    import pec_pkg::*;
#(
    parameter int unsigned NUM_CTR = PEC_NUM_CTR,
    parameter int unsigned CTR_W   = PEC_CTR_W,
    parameter int unsigned ADDR_W  = PEC_ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTR-1:0] evt_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic [CTR_W-1:0]   rdata_o
);
    localparam int unsigned FLAT_W = NUM_CTR * CTR_W;

    logic [NUM_CTR-1:0][CTR_W-1:0] live_arr, hold_arr;
    logic [FLAT_W-1:0]             live_flat, hold_flat;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_cell
        pec_ctl_t ctl;
        assign ctl.snap = wr_i;
        assign ctl.evt  = evt_i[g];
        pec_cell #(.CTR_W(CTR_W)) cell_i (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl),
            .live_o (live_arr[g]),
            .hold_o (hold_arr[g])
        );
    end

    assign live_flat = live_arr;
    assign hold_flat = hold_arr;

    pec_rd_port #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .ADDR_W  (ADDR_W)
    ) rd_i (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (addr_i),
        .hold_i  (hold_arr),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/pec_bank_chk.sv
module pec_bank_chk #(
    parameter int unsigned NUM_CTR = 3,
    parameter int unsigned CTR_W   = 16,
    parameter int unsigned ADDR_W  = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_CTR-1:0]         evt_i,
    input logic                       wr_i,
    input logic [ADDR_W-1:0]          addr_i,
    input logic [CTR_W-1:0]           rdata_o,
    input logic [NUM_CTR*CTR_W-1:0]   live_flat,
    input logic [NUM_CTR*CTR_W-1:0]   hold_flat
);
    localparam logic [CTR_W-1:0] TOP_VAL = {CTR_W{1'b1}};

    // R7: reset clears everything
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (rdata_o == '0 && live_flat == '0 && hold_flat == '0));

    // R6: out-of-range address reads zero
    p_oob_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(addr_i) >= NUM_CTR) |=> (rdata_o == '0));

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
        // R4: transfer clears the live counter
        p_snap_clear_r4: assert property (@(posedge clk) disable iff (rst)
            wr_i |=> (live_flat[g*CTR_W +: CTR_W] == '0));
        // R4: held value never below the live count it replaced
        p_snap_keep_r4: assert property (@(posedge clk) disable iff (rst)
            wr_i |=> (hold_flat[g*CTR_W +: CTR_W] >= $past(live_flat[g*CTR_W +: CTR_W])));
        // R3: a full counter stays full until a transfer
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            (!wr_i && live_flat[g*CTR_W +: CTR_W] == TOP_VAL)
            |=> (live_flat[g*CTR_W +: CTR_W] == TOP_VAL));
        // R2: no enable, no change
        p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
            (!wr_i && !evt_i[g]) |=> $stable(live_flat[g*CTR_W +: CTR_W]));
        // R5: holding register moves only on a transfer
        p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
            !wr_i |=> $stable(hold_flat[g*CTR_W +: CTR_W]));
    end
endmodule

bind pec_bank pec_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .live_flat (live_flat),
    .hold_flat (hold_flat)
);

// File: tb/pec_bank_tb_top.sv
`timescale 1ns/1ps
module pec_bank_tb_top;
    localparam int unsigned N  = 3;
    localparam int unsigned W  = 16;
    localparam int unsigned AW = 4;
    localparam int unsigned MAXV = (1 << W) - 1;

    // Stimulus table: burst length, burst event mask, event mask on the strobe cycle
    localparam int unsigned NV = 6;
    localparam int unsigned VEC_REPS [NV] = '{3, 10, 0, 7, 1, 25};
    localparam logic [2:0]  VEC_MASK [NV] = '{3'b001, 3'b111, 3'b000, 3'b010, 3'b100, 3'b101};
    localparam logic [2:0]  VEC_SEVT [NV] = '{3'b000, 3'b000, 3'b111, 3'b010, 3'b100, 3'b000};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  evt = '0;
    logic          wr  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  rdata;

    int unsigned live_m [N];
    int unsigned hold_m [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pec_bank #(.NUM_CTR(N), .CTR_W(W), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .evt_i(evt), .wr_i(wr), .addr_i(addr), .rdata_o(rdata)
    );

    function automatic int unsigned sat1(input int unsigned v);
        return (v >= MAXV) ? MAXV : v + 1;
    endfunction

    task automatic cyc(input logic [N-1:0] e, input logic w);
        @(negedge clk);
        evt = e; wr = w;
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            if (w) begin
                hold_m[i] = e[i] ? sat1(live_m[i]) : live_m[i];
                live_m[i] = 0;
            end else if (e[i]) begin
                live_m[i] = sat1(live_m[i]);
            end
        end
        evt = '0; wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int unsigned exp, input string req);
        @(negedge clk);
        addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rdata !== W'(exp)) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, rdata, exp);
        end
    endtask

    task automatic rd_all(input string req);
        for (int i = 0; i < N; i++) rd_chk(i, hold_m[i], req);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin live_m[i] = 0; hold_m[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R7 reset state, R6 out-of-range read
        rd_all("R7");
        rd_chk(5, 0, "R6");

        // Table walk: R1 R2 R4
        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < int'(VEC_REPS[v]); r++) cyc(VEC_MASK[v], 1'b0);
            cyc(VEC_SEVT[v], 1'b1);
            rd_all("R1/R2/R4");
        end

        // R5: events without strobe do not move the held values
        repeat (9) cyc(3'b111, 1'b0);
        rd_all("R5");

        // R4: event in the strobe cycle goes to the held value, not to the new live count
        cyc(3'b000, 1'b1);
        repeat (5) cyc(3'b001, 1'b0);
        cyc(3'b001, 1'b1);
        rd_chk(0, 6, "R4");
        cyc(3'b000, 1'b1);
        rd_chk(0, 0, "R4");

        // R3: saturation after a long run on counters 0 and 1
        @(negedge clk); evt = 3'b011;
        repeat (66000) @(posedge clk);
        #1; evt = '0;
        live_m[0] = MAXV; live_m[1] = MAXV;
        cyc(3'b011, 1'b1);
        rd_chk(0, MAXV, "R3");
        rd_chk(1, MAXV, "R3");
        rd_chk(2, 0, "R3");
        cyc(3'b000, 1'b1);
        rd_chk(0, 0, "R3");

        // R6: more out-of-range addresses after non-zero data
        repeat (4) cyc(3'b111, 1'b0);
        cyc(3'b000, 1'b1);
        rd_chk(3, 0, "R6");
        rd_chk(15, 0, "R6");
        rd_chk(2, 4, "R6");

        // R7: reset mid-run clears held values
        repeat (3) cyc(3'b111, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < N; i++) begin live_m[i] = 0; hold_m[i] = 0; end
        rd_all("R7");
        cyc(3'b000, 1'b1);
        rd_all("R7");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule